// File: doc/BRIEF.md
# UART FIFO Trigger Control Unit

This block holds the FIFO control state of one UART channel. It contains a transmit byte queue and a receive byte queue and turns their fill levels into two level-sensitive request outputs. Software programs it through an 8-bit control word. That word selects FIFO mode or single-byte holding mode, carries one flush command per queue, and picks a trigger threshold for each direction. The serial shifter pushes received bytes into the receive queue and pops bytes from the transmit queue. The processor or a DMA engine works the other end of each queue. That side reacts to `tx_req` and `rx_req`.

The two directions use different threshold tables. The transmit side asks for data when its fill level has dropped to the selected level or below it. The receive side asks to be drained when its fill level has reached the selected level or gone above it. A flush command bit stays set for exactly one cycle and then clears itself. In FIFO mode, a partly filled receive queue that has received nothing for a programmable number of cycles raises a timeout request. DMA-driven use is expected to run in holding mode.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset `reg_rdata` is 0x00. A write through `reg_wr` stores bits [7:6] (transmit select), [5:4] (receive select) and [0] (1 = FIFO mode, 0 = holding mode). These fields read back from the next cycle onward. Bit 3 always reads 0.
- R2: Writing 1 to bit 2 (transmit flush) or bit 1 (receive flush) sets that bit for one cycle. At the end of that cycle the selected queue becomes empty and the bit reads 0 again. The other queue is untouched. A push made during that cycle is dropped.
- R3: In FIFO mode each queue holds 64 bytes and returns them in push order. A push to a full queue is ignored. A pop from an empty queue is ignored.
- R4: In FIFO mode `tx_req` is 1 exactly when `tx_count` is at or below the transmit level. The transmit select maps 00, 01, 10 and 11 to levels 0, 16, 32 and 48.
- R5: In FIFO mode `rx_req` is 1 when `rx_count` is at or above the receive level. The receive select maps 00, 01, 10 and 11 to levels 1, 8, 16 and 32.
- R6: In holding mode each queue holds one byte. A second push is ignored and the held byte stays at the output. `tx_req` equals "transmit empty", `rx_req` equals "receive full", and the select fields have no effect.
- R7: A write that changes bit 0 empties both queues by the end of the following cycle.
- R8: In FIFO mode, when the receive queue is not empty and `idle_limit` cycles have passed since the last accepted receive push, `rx_timeout` and `rx_req` are 1. An accepted push clears the timeout. There is no timeout in holding mode or when `idle_limit` is 0.
- R9: After reset both counts are 0, `tx_req` is 1 and `rx_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| idle_limit | input | 16 | Receive idle cycles before a timeout (0 disables it) |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_din | input | 8 | Transmit push data |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_count | output | 7 | Transmit fill level |
| tx_req | output | 1 | Transmit service request |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_din | input | 8 | Receive push data |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_dout | output | 8 | Oldest receive byte |
| rx_count | output | 7 | Receive fill level |
| rx_req | output | 1 | Receive service request |
| rx_timeout | output | 1 | Receive idle timeout flag |

## Verification
A wrong pointer or count register appears at `tx_count`/`rx_count` and at the request outputs in the first cycle after the bad push, pop or flush. The bench samples each of these one clock after its stimulus. A flush bit that fails to clear, or a mode change that does not empty the queues, is visible within one cycle through `reg_rdata` and the counts. A wrong threshold mapping only appears when the fill level sits exactly at a level or one past it, so the vector table places fill levels on both sides of every level. An idle counter that is off by one moves the rise of `rx_timeout` by a single cycle, so the bench checks the cycle just before the timeout and the cycle it fires.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef struct packed {
      logic [1:0] tx_sel;
      logic [1:0] rx_sel;
      logic       rsvd;
      logic       tx_flush;
      logic       rx_flush;
      logic       fifo_en;
   } uft_ctrl_t;

   // transmit levels: quarter steps of the depth, 00 = empty
   function automatic int unsigned tx_level(input logic [1:0] sel, input int unsigned depth);
      return int'(sel) * (depth / 4);
   endfunction

   // receive levels: 00 = one byte, then depth/8, depth/4, depth/2
   function automatic int unsigned rx_level(input logic [1:0] sel, input int unsigned depth);
      if (sel == 2'd0) return 1;
      return depth >> (4 - int'(sel));
   endfunction

endpackage

// File: rtl/uft_ctrl_reg.sv
module uft_ctrl_reg
   import uft_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   output uft_ctrl_t  ctrl,
   output logic       mode_clr,
   output logic [7:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         mode_clr <= 1'b0;
      end else begin
         ctrl.tx_flush <= 1'b0;
         ctrl.rx_flush <= 1'b0;
         mode_clr      <= 1'b0;
         if (wr) begin
            ctrl.tx_sel   <= wdata[7:6];
            ctrl.rx_sel   <= wdata[5:4];
            ctrl.tx_flush <= wdata[2];
            ctrl.rx_flush <= wdata[1];
            ctrl.fifo_en  <= wdata[0];
            mode_clr      <= (wdata[0] != ctrl.fifo_en);
         end
      end
   end

   assign rdata = ctrl;

   // R2
   flush_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.tx_flush && !(wr && wdata[2])) |=> !ctrl.tx_flush);

   // R1
   wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (rdata[7:4] == $past(wdata[7:4])) && (rdata[0] == $past(wdata[0])));

endmodule

// File: rtl/uft_byte_fifo.sv
module uft_byte_fifo #(
   parameter int DEPTH = 64,
   parameter int DW    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fifo_en,
   input  logic                        flush,
   input  logic                        push,
   input  logic [DW-1:0]               din,
   input  logic                        pop,
   output logic [DW-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0]  count,
   output logic                        pushed
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 16) begin : g_bad_depth
         $error("uft_byte_fifo: DEPTH must be a power of two of at least 16");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cap;
   logic          full, popped;

   assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
   assign full   = (count >= cap);
   assign pushed = push && !full && !flush;
   assign popped = pop && (count != '0) && !flush;
   assign dout   = mem[rp];

   always_ff @(posedge clk) begin
      if (pushed) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (pushed) wp <= wp + AW'(1);
         if (popped) rp <= rp + AW'(1);
         case ({pushed, popped})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> count == $past(count));

   // R2
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> count == '0);

endmodule

// File: rtl/uft_trig_cmp.sv
module uft_trig_cmp
   import uft_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter bit IS_RX = 1'b0
) (
   input  logic                       fifo_en,
   input  logic [1:0]                 sel,
   input  logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       hit
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] lvl;

   generate
      if (IS_RX) begin : g_rx
         assign lvl = CW'(rx_level(sel, DEPTH));
         assign hit = fifo_en ? (count >= lvl) : (count != '0);
      end else begin : g_tx
         assign lvl = CW'(tx_level(sel, DEPTH));
         assign hit = fifo_en ? (count <= lvl) : (count == '0);
      end
   endgenerate

endmodule

// File: rtl/uft_rx_idle.sv
module uft_rx_idle #(
   parameter int TW = 16,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          pushed,
   input  logic [CW-1:0] count,
   input  logic [TW-1:0] limit,
   output logic          timeout
);

   logic [TW-1:0] idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        idle <= '0;
      else if (pushed || count == '0)    idle <= '0;
      else if (idle != {TW{1'b1}})       idle <= idle + TW'(1);
   end

   assign timeout = fifo_en && (limit != '0) && (count != '0) && (idle >= limit);

   // R8
   push_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pushed |=> !timeout);

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
   import uft_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   parameter int TOW   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [7:0]                 reg_wdata,
   output logic [7:0]                 reg_rdata,
   input  logic [TOW-1:0]             idle_limit,
   input  logic                       tx_push,
   input  logic [DW-1:0]              tx_din,
   input  logic                       tx_pop,
   output logic [DW-1:0]              tx_dout,
   output logic [$clog2(DEPTH+1)-1:0] tx_count,
   output logic                       tx_req,
   input  logic                       rx_push,
   input  logic [DW-1:0]              rx_din,
   input  logic                       rx_pop,
   output logic [DW-1:0]              rx_dout,
   output logic [$clog2(DEPTH+1)-1:0] rx_count,
   output logic                       rx_req,
   output logic                       rx_timeout
);

   localparam int CW = $clog2(DEPTH + 1);

   uft_ctrl_t ctrl;
   logic      mode_clr, tx_pushed, rx_pushed, rx_hit;

   uft_ctrl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .ctrl(ctrl), .mode_clr(mode_clr), .rdata(reg_rdata)
   );

   uft_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk(clk), .rst_n(rst_n), .fifo_en(ctrl.fifo_en),
      .flush(ctrl.tx_flush | mode_clr),
      .push(tx_push), .din(tx_din), .pop(tx_pop),
      .dout(tx_dout), .count(tx_count), .pushed(tx_pushed)
   );

   uft_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .fifo_en(ctrl.fifo_en),
      .flush(ctrl.rx_flush | mode_clr),
      .push(rx_push), .din(rx_din), .pop(rx_pop),
      .dout(rx_dout), .count(rx_count), .pushed(rx_pushed)
   );

   uft_trig_cmp #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_txcmp (
      .fifo_en(ctrl.fifo_en), .sel(ctrl.tx_sel), .count(tx_count), .hit(tx_req)
   );

   uft_trig_cmp #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rxcmp (
      .fifo_en(ctrl.fifo_en), .sel(ctrl.rx_sel), .count(rx_count), .hit(rx_hit)
   );

   uft_rx_idle #(.TW(TOW), .CW(CW)) u_idle (
      .clk(clk), .rst_n(rst_n), .fifo_en(ctrl.fifo_en), .pushed(rx_pushed),
      .count(rx_count), .limit(idle_limit), .timeout(rx_timeout)
   );

   assign rx_req = rx_hit | rx_timeout;

   // R6
   nonfifo_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.fifo_en && !mode_clr) |-> (tx_count <= CW'(1)) && (rx_count <= CW'(1)));

   // R7
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_clr |=> (tx_count == '0) && (rx_count == '0));

   // R3
   tx_accept_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pushed |=> tx_count != '0);

endmodule

// File: tb/sim_uart_fifo_trig_ctrl.sv
module sim_uart_fifo_trig_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic [15:0]   idle_limit = 16'd1000;
   logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0]    tx_din = '0, rx_din = '0, tx_dout, rx_dout;
   logic [CW-1:0] tx_count, rx_count;
   logic          tx_req, rx_req, rx_timeout;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_trig_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .idle_limit(idle_limit),
      .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
      .tx_count(tx_count), .tx_req(tx_req),
      .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
      .rx_count(rx_count), .rx_req(rx_req), .rx_timeout(rx_timeout)
   );

   // {ctrl, tx pushes, rx pushes, tx count, rx count, tx_req, rx_req}
   localparam logic [41:0] VEC [12] = '{
      {8'h07, 8'd0,  8'd0,  8'd0,  8'd0,  1'b1, 1'b0},
      {8'h07, 8'd1,  8'd1,  8'd1,  8'd1,  1'b0, 1'b1},
      {8'h57, 8'd16, 8'd7,  8'd16, 8'd7,  1'b1, 1'b0},
      {8'h57, 8'd17, 8'd8,  8'd17, 8'd8,  1'b0, 1'b1},
      {8'hA7, 8'd32, 8'd15, 8'd32, 8'd15, 1'b1, 1'b0},
      {8'hA7, 8'd33, 8'd16, 8'd33, 8'd16, 1'b0, 1'b1},
      {8'hF7, 8'd48, 8'd31, 8'd48, 8'd31, 1'b1, 1'b0},
      {8'hF7, 8'd49, 8'd32, 8'd49, 8'd32, 1'b0, 1'b1},
      {8'hF7, 8'd70, 8'd70, 8'd64, 8'd64, 1'b0, 1'b1},
      {8'h06, 8'd0,  8'd0,  8'd0,  8'd0,  1'b1, 1'b0},
      {8'h06, 8'd1,  8'd1,  8'd1,  8'd1,  1'b0, 1'b1},
      {8'hF6, 8'd3,  8'd3,  8'd1,  8'd1,  1'b0, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // write, then let the one-cycle flush/mode clear complete
   task automatic wr_ctrl(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      step(1);
      reg_wr = 1'b0;
      step(1);
   endtask

   task automatic push_n(input int ntx, input int nrx);
      for (int k = 0; k < ((ntx > nrx) ? ntx : nrx); k++) begin
         tx_push = (k < ntx); tx_din = 8'(k + 1);
         rx_push = (k < nrx); rx_din = 8'(k + 101);
         step(1);
      end
      tx_push = 1'b0; rx_push = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R9 / R1 reset state
      chk("R1 reset rdata", reg_rdata, 0);
      chk("R9 reset tx_count", tx_count, 0);
      chk("R9 reset rx_count", rx_count, 0);
      chk("R9 reset tx_req", tx_req, 1);
      chk("R9 reset rx_req", rx_req, 0);

      // R1 readback, bit 3 ignored, flush bits visible for one cycle (R2)
      reg_wr = 1'b1; reg_wdata = 8'hFF;
      step(1);
      reg_wr = 1'b0;
      chk("R1 readback first cycle", reg_rdata, 8'hF7);
      step(1);
      chk("R2 flush bits self-clear", reg_rdata, 8'hF1);

      // threshold and capacity table (R3 R4 R5 R6)
      for (int i = 0; i < 12; i++) begin
         wr_ctrl(VEC[i][41:34]);
         push_n(int'(VEC[i][33:26]), int'(VEC[i][25:18]));
         chk($sformatf("R3 R6 tx_count vec%0d", i), tx_count, int'(VEC[i][17:10]));
         chk($sformatf("R3 R6 rx_count vec%0d", i), rx_count, int'(VEC[i][9:2]));
         chk($sformatf("R4 R6 tx_req vec%0d", i), tx_req, int'(VEC[i][1]));
         chk($sformatf("R5 R6 rx_req vec%0d", i), rx_req, int'(VEC[i][0]));
      end

      // R6 held byte stays after an ignored second push
      wr_ctrl(8'h06);
      tx_push = 1'b1; tx_din = 8'h11; step(1);
      tx_din = 8'h22; step(1);
      tx_push = 1'b0;
      chk("R6 held byte kept", tx_dout, 8'h11);
      chk("R6 held count", tx_count, 1);

      // R7 mode change empties both queues
      wr_ctrl(8'h07);
      push_n(5, 4);
      wr_ctrl(8'h00);
      chk("R7 tx emptied", tx_count, 0);
      chk("R7 rx emptied", rx_count, 0);

      // R2 transmit flush leaves receive untouched
      wr_ctrl(8'h07);
      push_n(5, 4);
      wr_ctrl(8'h05);
      chk("R2 tx flushed", tx_count, 0);
      chk("R2 rx untouched", rx_count, 4);

      // R2 push during the flush cycle is dropped
      reg_wr = 1'b1; reg_wdata = 8'h05; step(1);
      reg_wr = 1'b0; tx_push = 1'b1; tx_din = 8'h33; step(1);
      tx_push = 1'b0;
      chk("R2 push in flush cycle dropped", tx_count, 0);
      chk("R2 flush bit cleared", reg_rdata[2], 0);

      // R3 order and empty pop
      wr_ctrl(8'h07);
      tx_push = 1'b1;
      tx_din = 8'hAA; step(1);
      tx_din = 8'hBB; step(1);
      tx_din = 8'hCC; step(1);
      tx_push = 1'b0;
      chk("R3 order first", tx_dout, 8'hAA);
      tx_pop = 1'b1; step(1); tx_pop = 1'b0;
      chk("R3 order second", tx_dout, 8'hBB);
      tx_pop = 1'b1; step(1); tx_pop = 1'b0;
      chk("R3 order third", tx_dout, 8'hCC);
      rx_pop = 1'b1; step(1); rx_pop = 1'b0;
      chk("R3 empty pop ignored", rx_count, 0);

      // R8 idle timeout, receive level 16
      idle_limit = 16'd5;
      wr_ctrl(8'h27);
      push_n(0, 3);
      step(4);
      chk("R8 no timeout before limit", rx_timeout, 0);
      chk("R8 rx_req before limit", rx_req, 0);
      step(1);
      chk("R8 timeout at limit", rx_timeout, 1);
      chk("R8 rx_req at limit", rx_req, 1);
      push_n(0, 1);
      chk("R8 push clears timeout", rx_timeout, 0);
      idle_limit = 16'd0;
      step(10);
      chk("R8 limit zero disables", rx_timeout, 0);

      // R8 none in holding mode
      idle_limit = 16'd5;
      wr_ctrl(8'h06);
      push_n(0, 1);
      step(10);
      chk("R8 no timeout in holding mode", rx_timeout, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule